// File: doc/BRIEF.md
# Field Memory Serial Read Port

This block is the read half of a field-sized delay memory. It runs on its own read clock, which has no fixed relation to the clock that fills the memory and may be faster or slower. A read address pointer walks through the storage, and each word it reaches is shown at the data output. The pointer can be returned to zero by a read reset strobe. The delay between storing a word and seeing it again is set only by how far apart the write-side reset and the read-side reset are issued.

Two controls shape the output stream. Read enable decides whether a clock edge advances the pointer at all. Output enable only decides whether the word that the edge produced is shown. With output enable low, the output is blanked to zero and flagged invalid, but the pointer still moves on, so words can be skipped without losing position.

Storage is a synchronous-read RAM outside the block. The block presents the address of the word it will need after the coming edge. The RAM registers that word on the same edge, so the word at the new pointer is already on the output once the edge has passed. This holds straight after a reset as well.

Top module: `field_rd_port`

## Requirements
- R1: While and after the asynchronous reset (rst_n low), rd_valid is 0, rd_data is all zeros and mem_addr is 0 until the first read-clock edge with a strobe or rd_en high.
- R2: On an edge with rd_en high and no honoured reset, the pointer steps by one. After that edge, rd_data shows the RAM word at the new pointer and rd_valid equals out_en as sampled on the edge.
- R3: An honoured reset strobe (rd_rst high on an edge) sets the pointer to 0 whatever rd_en is. After that same edge, word 0 is on rd_data, with rd_valid equal to out_en, and no further edge is needed.
- R4: On an edge with rd_en low and no honoured reset, the pointer, rd_data and rd_valid all keep their values.
- R5: On an advancing edge with out_en low, rd_valid becomes 0 and rd_data reads all zeros, while the pointer still steps. The skipped words are never shown.
- R6: A strobe held high over several consecutive edges keeps the pointer at 0 for each of those edges.
- R7: A strobe is honoured only in two cases: rd_rst was low on at least MIN_GAP edges (default 2) since the last honoured strobe, or the strobe directly continues an honoured strobe. Otherwise the edge acts as a normal cycle governed by rd_en, and it does not count as a low edge.
- R8: From DEPTH-1 the pointer wraps to 0 on the next advancing edge.
- R9: The word stored at write position k after a write reset is read out at read position k after a read reset. The delay therefore equals the spacing of the two resets.
- R10: mem_addr shows, combinationally from the current inputs, the pointer value that will hold after the coming edge. The RAM word addressed at one edge is what rd_data shows after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_rst | input | 1 | Read pointer reset strobe, sampled on the clock edge |
| rd_en | input | 1 | Advance enable for the pointer |
| out_en | input | 1 | Show (1) or blank (0) the word produced by the edge |
| mem_addr | output | ADDR_W | Address presented to the synchronous RAM |
| mem_rdata | input | DATA_W | Registered RAM read data |
| rd_data | output | DATA_W | Output word, zero when blanked |
| rd_valid | output | 1 | High when rd_data carries a shown word |

## Verification
The assertions check four things on every edge. A held cycle leaves the pointer and the valid flag unchanged. An advancing cycle steps the pointer by one, wrapping at DEPTH-1. The valid flag follows output enable on every advancing edge. The pointer always lands on the address that was presented to the RAM. Other behaviours need a live memory and are shown only by the bench's scenarios. These include: the word after a reset with no extra edge, skipped words whose position is kept, strobes rejected by the gap rule, and words written by an independent write clock coming back at the delay set by the reset spacing.

// File: rtl/field_rd_pkg.sv
package field_rd_pkg;
    // Default geometry: one field of 256K bytes.
    localparam int FRD_DEPTH   = 262144;
    localparam int FRD_DATA_W  = 8;
    // Minimum number of low strobe edges between two honoured resets.
    localparam int FRD_MIN_GAP = 2;
endpackage

// File: rtl/frd_rst_guard.sv
module frd_rst_guard #(
    parameter int MIN_GAP = 2,
    localparam int GAP_W = $clog2(MIN_GAP + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_rst,
    output logic rst_take
);
    typedef struct packed {
        logic [GAP_W-1:0] low_cnt;
        logic             held;
    } guard_t;

    localparam logic [GAP_W-1:0] GAP_LIM = GAP_W'(MIN_GAP);

    guard_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        rst_take = rd_rst && (st_q.held || (st_q.low_cnt >= GAP_LIM));
        if (rst_take) begin
            st_d.held    = 1'b1;
            st_d.low_cnt = '0;
        end else begin
            st_d.held = 1'b0;
            if (!rd_rst && (st_q.low_cnt < GAP_LIM)) begin
                st_d.low_cnt = st_q.low_cnt + GAP_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.low_cnt <= GAP_LIM;
            st_q.held    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/frd_addr_ctr.sv
module frd_addr_ctr #(
    parameter int DEPTH = 262144,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rst_take,
    input  logic              rd_en,
    output logic [ADDR_W-1:0] ptr_q,
    output logic [ADDR_W-1:0] ptr_d
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    typedef struct packed {
        logic [ADDR_W-1:0] ptr;
    } ctr_t;

    ctr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst_take) begin
            st_d.ptr = '0;
        end else if (rd_en) begin
            st_d.ptr = (st_q.ptr == LAST) ? '0 : st_q.ptr + ADDR_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ptr <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr_q = st_q.ptr;
    assign ptr_d = st_d.ptr;
endmodule

// File: rtl/frd_out_stage.sv
module frd_out_stage #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rst_take,
    input  logic              rd_en,
    input  logic              out_en,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    typedef struct packed {
        logic vld;
    } out_t;

    out_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst_take || rd_en) begin
            st_d.vld = out_en;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.vld <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_valid = st_q.vld;
    assign rd_data  = st_q.vld ? mem_rdata : '0;
endmodule

// File: rtl/field_rd_port.sv
module field_rd_port import field_rd_pkg::*; #(
    parameter int DEPTH   = FRD_DEPTH,
    parameter int DATA_W  = FRD_DATA_W,
    parameter int MIN_GAP = FRD_MIN_GAP,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_rst,
    input  logic              rd_en,
    input  logic              out_en,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    logic              rst_take;
    logic [ADDR_W-1:0] ptr_q;
    logic [ADDR_W-1:0] ptr_d;

    frd_rst_guard #(.MIN_GAP(MIN_GAP)) u_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_rst   (rd_rst),
        .rst_take (rst_take)
    );

    frd_addr_ctr #(.DEPTH(DEPTH)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .rst_take (rst_take),
        .rd_en    (rd_en),
        .ptr_q    (ptr_q),
        .ptr_d    (ptr_d)
    );

    frd_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .rst_take  (rst_take),
        .rd_en     (rd_en),
        .out_en    (out_en),
        .mem_rdata (mem_rdata),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid)
    );

    // Prefetch: the RAM registers the word for the pointer value after this edge.
    assign mem_addr = ptr_d;
endmodule

// File: rtl/field_rd_port_chk.sv
module field_rd_port_chk #(
    parameter int DEPTH = 262144,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_rst,
    input logic              rd_en,
    input logic              out_en,
    input logic [ADDR_W-1:0] ptr,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              rd_valid
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en && !rd_rst) |=> ($stable(ptr) && $stable(rd_valid)));

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_rst && ptr != LAST) |=> (ptr == $past(ptr) + ADDR_W'(1)));

    p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_rst && ptr == LAST) |=> (ptr == '0));

    p_skip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_rst) |=> (rd_valid == $past(out_en)));

    p_prefetch_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (ptr == $past(mem_addr)));
endmodule

bind field_rd_port field_rd_port_chk #(.DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_rst   (rd_rst),
    .rd_en    (rd_en),
    .out_en   (out_en),
    .ptr      (ptr_q),
    .mem_addr (mem_addr),
    .rd_valid (rd_valid)
);

// File: tb/field_rd_port_bench.sv
module field_rd_port_bench;
    localparam int DEPTH  = 1000;
    localparam int ADDR_W = $clog2(DEPTH);

    logic clk = 1'b0, wclk = 1'b0, rst_n = 1'b0;
    logic rd_rst = 1'b0, rd_en = 1'b0, out_en = 1'b0;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0] mem_rdata = 8'h00, rd_data;
    logic rd_valid;
    logic [7:0] mem [DEPTH];

    int n_chk = 0, n_fail = 0;
    bit run = 0, done = 0;
    string tag = "R1";

    // reference model state
    int m_ptr = 0, m_low = 2, m_gen = 0;
    bit m_vld = 0, m_held = 0, m_tk;

    always #10 clk = ~clk;   // 50 MHz read clock
    always #7 wclk = ~wclk;  // unrelated write clock

    field_rd_port #(.DEPTH(DEPTH), .DATA_W(8), .MIN_GAP(2)) u_field_rd_port (
        .clk(clk), .rst_n(rst_n), .rd_rst(rd_rst), .rd_en(rd_en), .out_en(out_en),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .rd_data(rd_data), .rd_valid(rd_valid));

    // synchronous-read RAM
    always @(posedge clk) mem_rdata <= mem[mem_addr];

    function automatic logic [7:0] pat(int i, int g);
        return 8'((i * 29 + 7 + g * 101) ^ (i >>> 5));
    endfunction

    function automatic int nxt(int p);
        return (p == DEPTH - 1) ? 0 : p + 1;
    endfunction

    function automatic bit take_now();
        return rd_rst && (m_held || m_low >= 2);
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(bit r, bit e, bit o);
        @(negedge clk); #2;
        rd_rst = r; rd_en = e; out_en = o;
        @(posedge clk); #3;
    endtask

    task automatic write_pass(int g);
        for (int i = 0; i < DEPTH; i++) begin
            @(posedge wclk);
            mem[i] = pat(i, g);
        end
    endtask

    // behavioural model, advanced on every read edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ptr = 0; m_vld = 0; m_low = 2; m_held = 0;
        end else begin
            m_tk = take_now();
            if (m_tk) begin
                m_ptr = 0; m_vld = out_en; m_low = 0; m_held = 1;
            end else begin
                m_held = 0;
                if (!rd_rst && m_low < 2) m_low++;
                if (rd_en) begin m_ptr = nxt(m_ptr); m_vld = out_en; end
            end
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && run) begin
            check(rd_valid == m_vld && rd_data == (m_vld ? pat(m_ptr, m_gen) : 8'h00), tag,
                  {rd_valid, rd_data}, {m_vld, (m_vld ? pat(m_ptr, m_gen) : 8'h00)});
            check(int'(mem_addr) == (take_now() ? 0 : (rd_en ? nxt(m_ptr) : m_ptr)), "R10",
                  int'(mem_addr), take_now() ? 0 : (rd_en ? nxt(m_ptr) : m_ptr));
        end
    end

    task automatic summary();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R2: actual hang expected completion (watchdog)");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        run = 1;
        @(posedge clk); #3;
        // R1: reset state
        check(rd_valid == 1'b0, "R1", rd_valid, 0);
        check(rd_data == 8'h00, "R1", rd_data, 0);
        check(mem_addr == '0, "R1", mem_addr, 0);

        write_pass(0);

        // R3: word 0 directly after the reset edge, rd_en ignored
        tag = "R3";
        cyc(1, 0, 1);
        check(rd_valid && rd_data == pat(0, 0), "R3", rd_data, pat(0, 0));

        tag = "R2";
        for (int k = 1; k <= 20; k++) begin
            cyc(0, 1, 1);
            check(rd_data == pat(k, 0), "R2", rd_data, pat(k, 0));
        end
        check(int'(mem_addr) == 21, "R10", mem_addr, 21);

        tag = "R4";
        repeat (5) cyc(0, 0, 1);
        check(rd_valid && rd_data == pat(20, 0), "R4", rd_data, pat(20, 0));
        check(int'(mem_addr) == 20, "R4", mem_addr, 20);

        tag = "R5";
        cyc(0, 1, 0);
        check(!rd_valid && rd_data == 8'h00, "R5", {rd_valid, rd_data}, 0);
        cyc(0, 1, 0);
        cyc(0, 1, 1);
        check(rd_valid && rd_data == pat(23, 0), "R5", rd_data, pat(23, 0));

        tag = "R6";
        for (int k = 0; k < 3; k++) begin
            cyc(1, 1, 1);
            check(rd_data == pat(0, 0), "R6", rd_data, pat(0, 0));
        end
        cyc(0, 1, 1);
        check(rd_data == pat(1, 0), "R6", rd_data, pat(1, 0));

        tag = "R7";
        cyc(1, 1, 1);   // only one low edge: acts as a normal advance
        check(rd_data == pat(2, 0), "R7", rd_data, pat(2, 0));
        cyc(0, 1, 1);
        check(rd_data == pat(3, 0), "R7", rd_data, pat(3, 0));
        cyc(1, 1, 1);   // two low edges now: honoured
        check(rd_data == pat(0, 0), "R7", rd_data, pat(0, 0));

        tag = "R8";
        for (int k = 1; k <= DEPTH + 2; k++) begin
            cyc(0, 1, 1);
            if (k == DEPTH - 1) check(rd_data == pat(DEPTH - 1, 0), "R8", rd_data, pat(DEPTH - 1, 0));
            if (k == DEPTH)     check(rd_data == pat(0, 0), "R8", rd_data, pat(0, 0));
            if (k == DEPTH + 2) check(rd_data == pat(2, 0), "R8", rd_data, pat(2, 0));
        end

        // R9: new field written on the other clock, read back after the reset spacing
        tag = "R9";
        cyc(0, 1, 0);
        m_gen = 1;
        fork
            write_pass(1);
        join_none
        repeat (10) cyc(0, 0, 0);
        cyc(1, 0, 1);
        check(rd_valid && rd_data == pat(0, 1), "R9", rd_data, pat(0, 1));
        for (int k = 1; k <= 300; k++) begin
            cyc(0, 1, 1);
            if (k == 150 || k == 300) check(rd_data == pat(k, 1), "R9", rd_data, pat(k, 1));
        end

        run = 0;
        done = 1;
        summary();
        $finish;
    end
endmodule